// File: doc/BRIEF.md
# Programmable Event-to-Interrupt Router

This block picks, for each of twelve maskable CPU interrupt lines (numbered 4 to 15), one event out of a 128-wide event vector. Events 0 to 3 are the combined events and events 4 to 127 are the individual system events. Any line may take any of these events, and several lines may take the same one. Software sets the choice through three 32-bit mapping registers. Each register holds four 7-bit event-number fields.

The selected event passes through one register stage to its interrupt line. A fixed-priority encoder watches the twelve lines and reports the number of the lowest-numbered active line, which is the most urgent one. A valid flag goes with that number. Line 4 has the highest priority and line 15 the lowest.

Top module: `irq_event_router`

## Requirements
- R1: While reset is asserted, all interrupt lines, `irq_valid` and `irq_idx` read zero, whatever the events do. After reset, line N (4..15) selects event N. Mapping register 0 therefore reads 0x07060504, register 1 reads 0x0B0A0908 and register 2 reads 0x0F0E0D0C.
- R2: Mapping register r (address r, 0..2) holds the fields for lines 4r+4, 4r+5, 4r+6 and 4r+7, at bits [6:0], [14:8], [22:16] and [30:24] in that order. A write takes effect at the next clock edge. A read returns the stored fields, and bits 7, 15, 23 and 31 always read zero.
- R3: Address 3 is not mapped. It reads zero, and a write to it changes no mapping register.
- R4: `irq_out[k]` (line k+4) equals the value that event `sel` had one clock earlier, where `sel` is line k+4's field. There is exactly one cycle of latency.
- R5: Every event number from 0 to 127 can be selected, including the combined events 0..3 and the top event 127.
- R6: Several lines may select the same event. They then assert together.
- R7: When any line is active, `irq_valid` is 1 and `irq_idx` gives the line number (4..15) of the lowest-numbered active line. This number is valid in the same cycle as `irq_out`.
- R8: When no line is active, `irq_valid` is 0 and `irq_idx` is 0.
- R9: Writing 0x37 into line 4's field (register 0, bits [6:0]) routes event 55 to line 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_in | input | 128 | Event vector, bit n is event n |
| cfg_we | input | 1 | Write strobe for the mapping registers |
| cfg_addr | input | 2 | Register address for both read and write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| irq_out | output | 12 | Interrupt lines, bit k is line k+4 |
| irq_idx | output | 4 | Number of the highest-priority active line |
| irq_valid | output | 1 | At least one line is active |

## Verification
A register write lands at the first rising edge after the strobe. A read at the following falling edge shows the new fields, because read data is combinational. An event change driven at a falling edge shows up on `irq_out`, `irq_idx` and `irq_valid` only after the next rising edge. The bench therefore samples at the falling edge after that edge. It also checks, one nanosecond after driving a new event vector, that the lines still carry the previous result, which confirms that the output is not early. The expected lines come from a shadow copy of the mapping fields kept by the bench.

// File: rtl/irq_evsel_pkg.sv
package irq_evsel_pkg;
  localparam int EVT_N    = 128;
  localparam int OUT_N    = 12;
  localparam int OUT_BASE = 4;
  localparam int REG_W    = 32;
  localparam int PER_REG  = 4;
  localparam int LANE_W   = REG_W / PER_REG;

  // bit offset of a line's field inside its mapping register
  function automatic int lane_lsb(input int k);
    return (k % PER_REG) * LANE_W;
  endfunction

  // register address that carries line k
  function automatic int lane_reg(input int k);
    return k / PER_REG;
  endfunction
endpackage

// File: rtl/irq_evsel_regs.sv
module irq_evsel_regs
  import irq_evsel_pkg::*;
#(
  parameter int OUT_N_P  = OUT_N,
  parameter int SEL_W    = 7,
  parameter int ADDR_W   = 2,
  parameter int BASE     = OUT_BASE
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [REG_W-1:0]         wdata,
  output logic [REG_W-1:0]         rdata,
  output logic [OUT_N_P*SEL_W-1:0] sel_flat
);
  logic [SEL_W-1:0] sel_q [OUT_N_P];

  for (genvar k = 0; k < OUT_N_P; k++) begin : g_field
    localparam int LSB = lane_lsb(k);
    localparam int RA  = lane_reg(k);
    always_ff @(posedge clk) begin
      if (!rst_n)
        sel_q[k] <= SEL_W'(k + BASE);
      else if (wr_en && addr == ADDR_W'(RA))
        sel_q[k] <= wdata[LSB +: SEL_W];
    end
    assign sel_flat[k*SEL_W +: SEL_W] = sel_q[k];
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < OUT_N_P; k++) begin
      if (addr == ADDR_W'(lane_reg(k)))
        rdata[lane_lsb(k) +: SEL_W] = sel_q[k];
    end
  end
endmodule

// File: rtl/irq_evsel_route.sv
module irq_evsel_route #(
  parameter int EVT_N_P = 128,
  parameter int OUT_N_P = 12,
  parameter int SEL_W   = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [EVT_N_P-1:0]       evt_in,
  input  logic [OUT_N_P*SEL_W-1:0] sel_flat,
  output logic [OUT_N_P-1:0]       lines
);
  for (genvar k = 0; k < OUT_N_P; k++) begin : g_line
    logic [SEL_W-1:0] sel;
    logic             pick;
    assign sel  = sel_flat[k*SEL_W +: SEL_W];
    assign pick = (int'(sel) < EVT_N_P) ? evt_in[sel] : 1'b0;
    always_ff @(posedge clk) begin
      if (!rst_n) lines[k] <= 1'b0;
      else        lines[k] <= pick;
    end
  end
endmodule

// File: rtl/irq_evsel_prio.sv
module irq_evsel_prio #(
  parameter int OUT_N_P = 12,
  parameter int BASE    = 4,
  parameter int IDX_W   = 4
) (
  input  logic [OUT_N_P-1:0] lines,
  output logic [IDX_W-1:0]   idx,
  output logic               valid
);
  // lowest set position, offset by the first line number
  function automatic logic [IDX_W-1:0] first_line(input logic [OUT_N_P-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = OUT_N_P - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i + BASE);
    return r;
  endfunction

  assign valid = |lines;
  assign idx   = first_line(lines);
endmodule

// File: rtl/irq_event_router.sv
module irq_event_router
  import irq_evsel_pkg::*;
#(
  parameter int EVT_N_P  = EVT_N,
  parameter int OUT_N_P  = OUT_N,
  parameter int BASE     = OUT_BASE,
  localparam int SEL_W   = $clog2(EVT_N_P),
  localparam int REG_N   = (OUT_N_P + PER_REG - 1) / PER_REG,
  localparam int ADDR_W  = $clog2(REG_N + 1),
  localparam int IDX_W   = $clog2(BASE + OUT_N_P)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [EVT_N_P-1:0] evt_in,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [REG_W-1:0]   cfg_wdata,
  output logic [REG_W-1:0]   cfg_rdata,
  output logic [OUT_N_P-1:0] irq_out,
  output logic [IDX_W-1:0]   irq_idx,
  output logic               irq_valid
);
  logic [OUT_N_P*SEL_W-1:0] sel_flat;

  irq_evsel_regs #(.OUT_N_P(OUT_N_P), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .BASE(BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .sel_flat(sel_flat)
  );

  irq_evsel_route #(.EVT_N_P(EVT_N_P), .OUT_N_P(OUT_N_P), .SEL_W(SEL_W)) u_route (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .sel_flat(sel_flat), .lines(irq_out)
  );

  irq_evsel_prio #(.OUT_N_P(OUT_N_P), .BASE(BASE), .IDX_W(IDX_W)) u_prio (
    .lines(irq_out), .idx(irq_idx), .valid(irq_valid)
  );
endmodule

// File: rtl/irq_event_router_chk.sv
module irq_event_router_chk #(
  parameter int EVT_N_P = 128,
  parameter int OUT_N_P = 12,
  parameter int BASE    = 4,
  parameter int SEL_W   = 7,
  parameter int ADDR_W  = 2,
  parameter int IDX_W   = 4,
  parameter int REG_N   = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [EVT_N_P-1:0]       evt_in,
  input logic                     cfg_we,
  input logic [ADDR_W-1:0]        cfg_addr,
  input logic [31:0]              cfg_rdata,
  input logic [OUT_N_P-1:0]       irq_out,
  input logic [IDX_W-1:0]         irq_idx,
  input logic                     irq_valid,
  input logic [OUT_N_P*SEL_W-1:0] sel_flat
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  logic [31:0] rsv_mask;
  always_comb begin
    rsv_mask = '1;
    for (int f = 0; f < 4; f++) rsv_mask[f*8 +: SEL_W] = '0;
  end

  int               off;
  logic [OUT_N_P-1:0] below;
  logic             hit_line;
  always_comb begin
    off      = int'(irq_idx) - BASE;
    below    = '0;
    hit_line = 1'b0;
    for (int i = 0; i < OUT_N_P; i++) begin
      if (i < off)  below[i] = irq_out[i];
      if (i == off) hit_line = irq_out[i];
    end
  end

  for (genvar k = 0; k < OUT_N_P; k++) begin : g_chk
    assert_route_latency_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      irq_out[k] == $past(evt_in[sel_flat[k*SEL_W +: SEL_W]]));
  end

  assert_fields_hold_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(cfg_we) |-> $stable(sel_flat));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & rsv_mask) == 32'h0);

  assert_unmapped_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cfg_addr) >= REG_N) |-> cfg_rdata == 32'h0);

  assert_prio_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (off >= 0 && off < OUT_N_P && hit_line && below == '0));

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (irq_out == '0 && irq_idx == '0));
endmodule

bind irq_event_router irq_event_router_chk #(
  .EVT_N_P(EVT_N_P), .OUT_N_P(OUT_N_P), .BASE(BASE), .SEL_W(SEL_W),
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .REG_N(REG_N)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_rdata(cfg_rdata), .irq_out(irq_out), .irq_idx(irq_idx), .irq_valid(irq_valid),
  .sel_flat(sel_flat)
);

// File: tb/test_irq_event_router.sv
module test_irq_event_router;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [127:0] evt_in;
  logic         cfg_we;
  logic [1:0]   cfg_addr;
  logic [31:0]  cfg_wdata;
  logic [31:0]  cfg_rdata;
  logic [11:0]  irq_out;
  logic [3:0]   irq_idx;
  logic         irq_valid;

  always #5 clk = ~clk;

  irq_event_router i_irq_event_router (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_out(irq_out),
    .irq_idx(irq_idx), .irq_valid(irq_valid)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [6:0]  shadow [12];
  logic [11:0] prev_exp;

  // {line offset k (line k+4), event number}
  localparam logic [10:0] VEC [8] = '{
    {4'd0, 7'd0}, {4'd11, 7'd127}, {4'd5, 7'd64}, {4'd3, 7'd31},
    {4'd7, 7'd96}, {4'd2, 7'd1}, {4'd9, 7'd100}, {4'd1, 7'd3}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] shadow_reg(input int r);
    logic [31:0] v = '0;
    for (int j = 0; j < 4; j++) v[j*8 +: 7] = shadow[r*4 + j];
    return v;
  endfunction

  task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < 2'd3)
      for (int j = 0; j < 4; j++) shadow[a*4 + j] = d[j*8 +: 7];
  endtask

  task automatic read_check(input string req, input logic [1:0] a, input logic [31:0] exp);
    cfg_addr = a;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  task automatic apply_evt(input string req, input logic [127:0] v);
    logic [11:0] e;
    logic [3:0]  ix;
    for (int k = 0; k < 12; k++) e[k] = v[shadow[k]];
    ix = '0;
    for (int k = 11; k >= 0; k--) if (e[k]) ix = 4'(k + 4);
    evt_in = v;
    #1;
    check({req, " R4 latency"}, 32'(irq_out), 32'(prev_exp));
    @(negedge clk);
    check({req, " R4 lines"}, 32'(irq_out), 32'(e));
    check({req, " R7 idx"}, 32'(irq_idx), 32'(ix));
    check({req, " R8 valid"}, 32'(irq_valid), 32'(|e));
    prev_exp = e;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; evt_in = '1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    for (int k = 0; k < 12; k++) shadow[k] = 7'(k + 4);
    prev_exp = '0;
    repeat (3) @(negedge clk);
    check("R1 lines in reset", 32'(irq_out), 32'h0);
    check("R1 valid in reset", 32'(irq_valid), 32'h0);
    check("R1 idx in reset", 32'(irq_idx), 32'h0);
    for (int r = 0; r < 3; r++) read_check("R1 reset map", 2'(r), shadow_reg(r));
    evt_in = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // default mapping: event 9 drives line 9 only
    apply_evt("R1 default route", 128'(1) << 9);

    // table walk: program one field, raise its event
    for (int t = 0; t < 8; t++) begin
      int k, ev;
      k  = int'(VEC[t][10:7]);
      ev = int'(VEC[t][6:0]);
      shadow[k] = 7'(ev);
      write_reg(2'(k / 4), shadow_reg(k / 4));
      read_check("R2 readback", 2'(k / 4), shadow_reg(k / 4));
      apply_evt("R5 table", 128'(1) << ev);
      apply_evt("R5 neighbour", 128'(1) << (ev ^ 1));
    end

    // reserved bits
    write_reg(2'd1, 32'hFFFF_FFFF);
    read_check("R2 reserved bits", 2'd1, 32'h7F7F_7F7F);

    // unmapped address
    write_reg(2'd3, 32'h0102_0304);
    read_check("R3 unmapped read", 2'd3, 32'h0);
    for (int r = 0; r < 3; r++) read_check("R3 no side effect", 2'(r), shadow_reg(r));

    // shared event
    write_reg(2'd2, 32'h4D4D_4D4D);
    apply_evt("R6 shared", 128'(1) << 77);
    check("R6 shared lines", 32'(irq_out), 32'h0000_0F00);

    // priority
    apply_evt("R7 all events", '1);
    check("R7 top priority", 32'(irq_idx), 32'd4);
    write_reg(2'd2, 32'h784D_4D4D);
    apply_evt("R7 lowest only", 128'(1) << 120);
    check("R7 line 15", 32'(irq_idx), 32'd15);
    apply_evt("R8 none", '0);

    // line 4 to event 55
    write_reg(2'd0, (shadow_reg(0) & 32'hFFFF_FF00) | 32'h37);
    read_check("R9 field", 2'd0, shadow_reg(0));
    apply_evt("R9 event 55", 128'(1) << 55);
    check("R9 line 4", 32'(irq_out[0]), 32'h1);

    done = 1'b1;
    finish_run();
  end
endmodule